// File: doc/BRIEF.md
# Multi-channel SPI master register bank

This block is the register front end of a SPI master with several chip-select channels. A simple 32-bit register bus reaches a small set of global registers: an identification word, a system configuration word with a soft-reset trigger, a status word that reports reset completion, and a mode word. It also reaches one register bank per channel, placed at a fixed 0x14-byte stride. Each bank holds a configuration word, a status word, a control word and the transmit and receive data words.

The serial shifter is a separate block. It sees each channel through a word-plus-handshake port. It takes transmit words, pushes received words and signals end of transfer, and it sees the channel configuration and enable. For each channel the bank raises element-paced DMA requests toward a DMA engine. A transmit request asks for the next word while the transmit register is empty. A receive request asks for a pickup while the receive register is full. Each kind has its own enable bit in the channel configuration.

Top module: `mspi_regbank`

## Requirements
- R1: Address 0x00 reads the REV parameter. Addresses 0x18, 0x1C, 0x20 and 0x24 read zero and ignore writes.
- R2: In the system configuration word at 0x10, bit 0 is a read/write autoidle flag, driven on `autoidle`. Writing 1 to bit 1 starts a soft reset, and bit 1 always reads 0.
- R3: Bit 0 of the system status word at 0x14 reads 0 from the cycle after a soft-reset write for RST_CYCLES cycles, then reads 1. When the soft reset completes, every global and channel register holds its reset value.
- R4: In the mode word at 0x28, bit 0 is single-channel, bit 2 is slave and bit 3 is test. All three are read/write and drive `mode_single`, `mode_slave` and `mode_test`. Other bits read 0. The reset value is 0x4 (slave).
- R5: Channel n's bank starts at 0x2C + n*0x14. Within it, config is at +0x0, status at +0x4, control at +0x8, transmit at +0xC and receive at +0x10. Config is a full 32-bit read/write word, driven on `ch_cfg`.
- R6: Control bit 0 enables the channel and drives `ch_en`. On a disabled channel, the shifter's take, push and end-of-transfer strobes have no effect.
- R7: The status word has bit 0 for receive full, bit 1 for transmit empty and bit 2 for end of transfer. Its reset value is 0x2.
- R8: A transmit write stores the word, clears transmit-empty and end-of-transfer, and presents the word with `eng_tx_valid` high. A take strobe on an enabled channel that holds a word sets transmit-empty again.
- R9: A push on an enabled channel stores the received word and sets receive-full. Reading the receive register returns that word and clears receive-full, unless a push arrives in the same cycle.
- R10: An end-of-transfer strobe on an enabled channel sets status bit 2.
- R11: `dma_tx_req` is high while config bit 14, the enable and transmit-empty are all set. It is low in the cycle after a transmit-register write.
- R12: `dma_rx_req` is high while config bit 15, the enable and receive-full are all set. It is low in the cycle after a receive-register read.
- R13: Addresses from the end of the last implemented bank up to the top of the address space read zero and change no register.
- R14: A read returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| mode_single | output | 1 | Single-channel mode |
| mode_slave | output | 1 | Slave mode |
| mode_test | output | 1 | Test mode |
| autoidle | output | 1 | Autoidle flag |
| ch_en | output | NUM_CH | Channel enables |
| ch_cfg | output | NUM_CH*DW | Channel configuration words |
| eng_tx_word | output | NUM_CH*DW | Transmit words to the shifter |
| eng_tx_valid | output | NUM_CH | Transmit word loaded on an enabled channel |
| eng_tx_take | input | NUM_CH | Shifter took the transmit word |
| eng_rx_word | input | NUM_CH*DW | Received words from the shifter |
| eng_rx_push | input | NUM_CH | Received word valid |
| eng_eot | input | NUM_CH | End-of-transfer strobes |
| dma_tx_req | output | NUM_CH | Transmit DMA requests |
| dma_rx_req | output | NUM_CH | Receive DMA requests |

## Verification
The assertions watch four things on every cycle. A transmit write empties nothing and drops the transmit request on the next cycle. A receive read drops receive-full and the receive request. The reset-done flag falls right after a soft-reset write. The mode word comes back as slave when a soft reset ends. The bench scenarios are needed for the rest: address decoding across the channel stride, silence on disabled channels, the level behaviour of DMA requests as the shifter takes and pushes words, the zero window above the last bank, and the full clearing of state after a soft reset.

// File: rtl/mspi_pkg.sv
package mspi_pkg;
  localparam logic [7:0] OFS_REV     = 8'h00;
  localparam logic [7:0] OFS_SYSCFG  = 8'h10;
  localparam logic [7:0] OFS_SYSSTAT = 8'h14;
  localparam logic [7:0] OFS_MODE    = 8'h28;
  localparam int         CH_BASE     = 'h2C;
  localparam int         CH_STRIDE   = 'h14;
  // register offsets inside one channel bank
  localparam int REG_CFG  = 'h0;
  localparam int REG_STAT = 'h4;
  localparam int REG_CTRL = 'h8;
  localparam int REG_TX   = 'hC;
  localparam int REG_RX   = 'h10;
  // config bits for DMA request enables
  localparam int CFG_DMA_TX = 14;
  localparam int CFG_DMA_RX = 15;
endpackage

// File: rtl/mspi_glob.sv
module mspi_glob #(
  parameter int          RST_CYCLES = 8,
  parameter logic [31:0] REV        = 32'h0000_0031
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cfg,
  input  logic        wr_mode,
  input  logic [3:0]  wbits,
  output logic [31:0] rd_rev,
  output logic [31:0] rd_cfg,
  output logic [31:0] rd_stat,
  output logic [31:0] rd_mode,
  output logic        srst_busy,
  output logic        autoidle,
  output logic        mode_single,
  output logic        mode_slave,
  output logic        mode_test
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          srst_go;

  assign srst_go   = wr_cfg & wbits[1] & ~srst_busy;
  assign srst_busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (srst_go) cnt <= CW'(RST_CYCLES);
    else if (srst_busy) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || srst_busy) begin
      autoidle    <= 1'b0;
      mode_single <= 1'b0;
      mode_slave  <= 1'b1;
      mode_test   <= 1'b0;
    end else begin
      if (wr_cfg) autoidle <= wbits[0];
      if (wr_mode) begin
        mode_single <= wbits[0];
        mode_slave  <= wbits[2];
        mode_test   <= wbits[3];
      end
    end
  end

  assign rd_rev  = REV;
  assign rd_cfg  = {31'b0, autoidle};
  assign rd_stat = {31'b0, ~srst_busy};
  assign rd_mode = {28'b0, mode_test, mode_slave, 1'b0, mode_single};

  // R3
  srst_done_chk: assert property (@(posedge clk) disable iff (rst)
    srst_go |=> !rd_stat[0]);
  // R4
  slave_default_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(srst_busy) |-> (mode_slave && !mode_single && !mode_test));
endmodule

// File: rtl/mspi_chan.sv
module mspi_chan
  import mspi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cfg,
  input  logic          wr_ctrl,
  input  logic          wr_tx,
  input  logic          rd_rx,
  input  logic [DW-1:0] wdata,
  input  logic          tx_take,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_word,
  input  logic          eot_in,
  output logic [DW-1:0] cfg,
  output logic          en,
  output logic [2:0]    stat,
  output logic [DW-1:0] tx_word,
  output logic          tx_valid,
  output logic [DW-1:0] rx_q,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  logic tx_empty, rx_full, eot;
  logic take_ok, push_ok, eot_ok;
  logic dtx_q, drx_q;

  assign take_ok = en & tx_take & ~tx_empty;
  assign push_ok = en & rx_push;
  assign eot_ok  = en & eot_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      en       <= 1'b0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      eot      <= 1'b0;
      tx_word  <= '0;
      rx_q     <= '0;
      dtx_q    <= 1'b0;
      drx_q    <= 1'b0;
    end else begin
      if (wr_cfg)  cfg <= wdata;
      if (wr_ctrl) en  <= wdata[0];
      if (take_ok) tx_empty <= 1'b1;
      if (eot_ok)  eot <= 1'b1;
      if (wr_tx) begin
        tx_word  <= wdata;
        tx_empty <= 1'b0;
        eot      <= 1'b0;
      end
      if (rd_rx) rx_full <= 1'b0;
      if (push_ok) begin
        rx_q    <= rx_word;
        rx_full <= 1'b1;
      end
      dtx_q <= cfg[CFG_DMA_TX] & en & tx_empty & ~wr_tx;
      drx_q <= cfg[CFG_DMA_RX] & en & rx_full & ~rd_rx;
    end
  end

  assign stat       = {eot, tx_empty, rx_full};
  assign tx_valid   = en & ~tx_empty;
  assign dma_tx_req = dtx_q & en;
  assign dma_rx_req = drx_q & en;

  // R8
  tx_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !tx_empty);
  // R11
  dma_tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !dma_tx_req);
  // R12
  dma_rx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rd_rx |=> !dma_rx_req);
  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && !push_ok) |=> !rx_full);
endmodule

// File: rtl/mspi_regbank.sv
module mspi_regbank
  import mspi_pkg::*;
#(
  parameter int          NUM_CH     = 4,
  parameter int          AW         = 8,
  parameter int          DW         = 32,
  parameter int          RST_CYCLES = 8,
  parameter logic [31:0] REV        = 32'h0000_0031
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_rvalid,
  output logic                 mode_single,
  output logic                 mode_slave,
  output logic                 mode_test,
  output logic                 autoidle,
  output logic [NUM_CH-1:0]    ch_en,
  output logic [NUM_CH*DW-1:0] ch_cfg,
  output logic [NUM_CH*DW-1:0] eng_tx_word,
  output logic [NUM_CH-1:0]    eng_tx_valid,
  input  logic [NUM_CH-1:0]    eng_tx_take,
  input  logic [NUM_CH*DW-1:0] eng_rx_word,
  input  logic [NUM_CH-1:0]    eng_rx_push,
  input  logic [NUM_CH-1:0]    eng_eot,
  output logic [NUM_CH-1:0]    dma_tx_req,
  output logic [NUM_CH-1:0]    dma_rx_req
);
  logic          wr, rd;
  logic          srst_busy, ch_rst;
  logic [31:0]   g_rev, g_cfg, g_stat, g_mode;
  logic [NUM_CH-1:0] hit;
  logic [DW-1:0] ch_rd [NUM_CH];
  logic [DW-1:0] rdata_n;

  assign wr     = bus_sel & bus_wr;
  assign rd     = bus_sel & ~bus_wr;
  assign ch_rst = rst | srst_busy;

  mspi_glob #(.RST_CYCLES(RST_CYCLES), .REV(REV)) u_glob (
    .clk(clk), .rst(rst),
    .wr_cfg(wr && bus_addr == AW'(OFS_SYSCFG)),
    .wr_mode(wr && bus_addr == AW'(OFS_MODE)),
    .wbits(bus_wdata[3:0]),
    .rd_rev(g_rev), .rd_cfg(g_cfg), .rd_stat(g_stat), .rd_mode(g_mode),
    .srst_busy(srst_busy), .autoidle(autoidle),
    .mode_single(mode_single), .mode_slave(mode_slave), .mode_test(mode_test)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int BASE = CH_BASE + n * CH_STRIDE;
    logic [AW-1:0] loc;
    logic [2:0]    stat;
    logic [DW-1:0] cfg_w, txw, rxq;
    logic          en_w;

    assign hit[n] = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + CH_STRIDE);
    assign loc    = bus_addr - AW'(BASE);

    mspi_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(ch_rst),
      .wr_cfg (wr & hit[n] & (loc == AW'(REG_CFG))),
      .wr_ctrl(wr & hit[n] & (loc == AW'(REG_CTRL))),
      .wr_tx  (wr & hit[n] & (loc == AW'(REG_TX))),
      .rd_rx  (rd & hit[n] & (loc == AW'(REG_RX))),
      .wdata(bus_wdata),
      .tx_take(eng_tx_take[n]),
      .rx_push(eng_rx_push[n]),
      .rx_word(eng_rx_word[n*DW +: DW]),
      .eot_in(eng_eot[n]),
      .cfg(cfg_w), .en(en_w), .stat(stat),
      .tx_word(txw), .tx_valid(eng_tx_valid[n]), .rx_q(rxq),
      .dma_tx_req(dma_tx_req[n]), .dma_rx_req(dma_rx_req[n])
    );

    assign ch_en[n]              = en_w;
    assign ch_cfg[n*DW +: DW]    = cfg_w;
    assign eng_tx_word[n*DW +: DW] = txw;

    always_comb begin
      ch_rd[n] = '0;
      if (hit[n]) begin
        case (int'(loc))
          REG_CFG:  ch_rd[n] = cfg_w;
          REG_STAT: ch_rd[n] = DW'(stat);
          REG_CTRL: ch_rd[n] = DW'(en_w);
          REG_TX:   ch_rd[n] = txw;
          REG_RX:   ch_rd[n] = rxq;
          default:  ch_rd[n] = '0;
        endcase
      end
    end
  end

  always_comb begin
    rdata_n = '0;
    if (bus_addr == AW'(OFS_REV))          rdata_n = DW'(g_rev);
    else if (bus_addr == AW'(OFS_SYSCFG))  rdata_n = DW'(g_cfg);
    else if (bus_addr == AW'(OFS_SYSSTAT)) rdata_n = DW'(g_stat);
    else if (bus_addr == AW'(OFS_MODE))    rdata_n = DW'(g_mode);
    for (int n = 0; n < NUM_CH; n++) rdata_n = rdata_n | ch_rd[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rdata_n;
    end
  end

  // R14
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid);
endmodule

// File: tb/sim_mspi_regbank.sv
module sim_mspi_regbank;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int RSTC = 8;
  localparam logic [31:0] REVV = 32'h0000_0031;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, mode_single, mode_slave, mode_test, autoidle;
  logic [NCH-1:0] ch_en, eng_tx_valid, dma_tx_req, dma_rx_req;
  logic [NCH*DW-1:0] ch_cfg, eng_tx_word;
  logic [NCH-1:0] eng_tx_take = '0, eng_rx_push = '0, eng_eot = '0;
  logic [NCH*DW-1:0] eng_rx_word = '0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] q_d[$];
  string q_t[$];

  always #2 clk = ~clk;

  mspi_regbank #(.NUM_CH(NCH), .RST_CYCLES(RSTC), .REV(REVV)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .mode_single(mode_single), .mode_slave(mode_slave), .mode_test(mode_test),
    .autoidle(autoidle), .ch_en(ch_en), .ch_cfg(ch_cfg), .eng_tx_word(eng_tx_word),
    .eng_tx_valid(eng_tx_valid), .eng_tx_take(eng_tx_take), .eng_rx_word(eng_rx_word),
    .eng_rx_push(eng_rx_push), .eng_eot(eng_eot), .dma_tx_req(dma_tx_req),
    .dma_rx_req(dma_rx_req));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  // driver: issue a read and queue the expected word for the monitor
  task automatic bus_read(logic [7:0] a, logic [31:0] e, string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    q_d.push_back(e); q_t.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  // monitor: compare each returned word against the scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (q_d.size() == 0) chk("R14 unexpected rvalid", 32'd1, 32'd0);
      else chk(q_t.pop_front(), bus_rdata, q_d.pop_front());
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    // reset state
    bus_read(8'h00, REVV, "R1 revision");
    bus_read(8'h14, 32'h1, "R3 reset done after reset");
    bus_read(8'h28, 32'h4, "R4 mode reset value");
    bus_read(8'h30, 32'h2, "R7 ch0 status reset");
    bus_read(8'h6C, 32'h2, "R7 ch3 status reset");
    chk("R4 slave out", {31'b0, mode_slave}, 32'h1);
    // unused global and mode word
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_read(8'h18, 32'h0, "R1 unused global reads zero");
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_read(8'h28, 32'hD, "R4 mode bits");
    bus_write(8'h10, 32'h1);
    bus_read(8'h10, 32'h1, "R2 autoidle readback");
    chk("R2 autoidle out", {31'b0, autoidle}, 32'h1);
    // channel config stride
    bus_write(8'h54, 32'h0000_C123);
    bus_read(8'h54, 32'h0000_C123, "R5 ch2 config");
    chk("R5 ch_cfg ch2", ch_cfg[2*DW +: DW], 32'h0000_C123);
    bus_read(8'h40, 32'h0, "R5 ch1 config untouched");
    // disabled channel ignores the shifter
    eng_rx_word[DW +: DW] = 32'h77; eng_rx_push[1] = 1; eng_eot[1] = 1;
    idle(1);
    eng_rx_push[1] = 0; eng_eot[1] = 0;
    bus_read(8'h44, 32'h2, "R6 disabled ch1 ignores push/eot");
    // enable ch1 with both DMA enables
    bus_write(8'h40, 32'h0000_C000);
    bus_write(8'h48, 32'h1);
    chk("R6 ch_en ch1", {31'b0, ch_en[1]}, 32'h1);
    idle(2);
    chk("R11 tx req when empty", {31'b0, dma_tx_req[1]}, 32'h1);
    chk("R12 no rx req when not full", {31'b0, dma_rx_req[1]}, 32'h0);
    // transmit word
    bus_write(8'h4C, 32'hA5A5_1234);
    chk("R11 tx req drops after TX write", {31'b0, dma_tx_req[1]}, 32'h0);
    chk("R8 tx valid", {31'b0, eng_tx_valid[1]}, 32'h1);
    chk("R8 tx word", eng_tx_word[DW +: DW], 32'hA5A5_1234);
    bus_read(8'h44, 32'h0, "R8 status after TX write");
    // shifter takes, ends, pushes
    eng_tx_take[1] = 1; idle(1); eng_tx_take[1] = 0;
    eng_eot[1] = 1; idle(1); eng_eot[1] = 0;
    eng_rx_word[DW +: DW] = 32'h0000_005A; eng_rx_push[1] = 1; idle(1); eng_rx_push[1] = 0;
    idle(1);
    chk("R12 rx req when full", {31'b0, dma_rx_req[1]}, 32'h1);
    chk("R11 tx req after take", {31'b0, dma_tx_req[1]}, 32'h1);
    chk("R8 tx valid cleared by take", {31'b0, eng_tx_valid[1]}, 32'h0);
    bus_read(8'h44, 32'h7, "R7 R10 status full/empty/eot");
    bus_read(8'h50, 32'h0000_005A, "R9 rx word");
    chk("R12 rx req drops after RX read", {31'b0, dma_rx_req[1]}, 32'h0);
    bus_read(8'h44, 32'h6, "R9 rx full cleared");
    bus_write(8'h4C, 32'h11);
    bus_read(8'h44, 32'h0, "R8 TX write clears eot");
    // beyond the last bank
    bus_write(8'h80, 32'hFFFF_FFFF);
    bus_write(8'h7C, 32'hFFFF_FFFF);
    bus_read(8'h80, 32'h0, "R13 above last bank reads zero");
    bus_read(8'h7C, 32'h0, "R13 first unmapped word reads zero");
    bus_read(8'h68, 32'h0, "R13 ch3 config not aliased");
    bus_read(8'h2C, 32'h0, "R13 ch0 config not aliased");
    // soft reset
    bus_write(8'h10, 32'h2);
    bus_read(8'h14, 32'h0, "R3 reset in progress");
    idle(RSTC + 2);
    bus_read(8'h14, 32'h1, "R3 reset done");
    bus_read(8'h28, 32'h4, "R3 mode restored");
    bus_read(8'h10, 32'h0, "R2 R3 sysconfig cleared");
    bus_read(8'h54, 32'h0, "R3 ch2 config cleared");
    bus_read(8'h44, 32'h2, "R3 ch1 status restored");
    chk("R3 ch_en cleared", {28'b0, ch_en}, 32'h0);
    idle(3);
    if (q_d.size() != 0) chk("R14 missing read data", q_d.size(), 32'd0);
    summary();
  end
endmodule